// File: doc/BRIEF.md
# Smartcard Character Transceiver with Retry

This block moves single characters over one shared, open-drain smartcard data line in half-duplex. A character has a low start bit, eight data bits with the least significant bit first, and an even parity bit. The block transmits a byte that is offered on a valid strobe. It receives characters that a card sends, and it handles the parity-error handshake: a receiver that sees bad parity pulls the line low just after the parity bit, and a transmitter that sees that pulse sends the same character again.

Timing comes from `half_tick`, a one-cycle strobe that occurs twice per elementary time unit (ETU). All tick positions below count half-ETU ticks. For transmit, tick 0 is the tick that drives the start bit low. For receive, tick 0 is the tick on which the low start bit is first seen. Each direction has its own retry enable and a 3-bit limit field that holds the allowed retry count minus one, so a field value of 0 allows 1 retry and 7 allows 8. When the enable is low, no retry is allowed.

Transmit states: TX_IDLE (accept a byte), TX_ARM (wait for a tick, then drive the start bit), TX_SEND (start, data and parity bits), TX_STOP (release the line, check for rejection, then finish, resend or fail). The transitions are: IDLE→ARM on an accepted byte, ARM→SEND on a tick, SEND→STOP at tick 20, STOP→IDLE at the end of the stop time or when retries are exhausted, and STOP→ARM on a rejection that still has a retry left. Receive states: RX_IDLE (watch for a start bit), RX_BITS (sample the data and parity bits), RX_TAIL (let the stop period pass), RX_SIGNAL (drive the error pulse). The transitions are: IDLE→BITS on a start bit, BITS→TAIL when parity is good or retries are exhausted, BITS→SIGNAL on bad parity with a retry left, TAIL→IDLE at tick 20, and SIGNAL→IDLE at tick 23.

Top module: `sc_char_xcvr`

## Requirements
- R1: After reset the line is released (`io_drive_low`=0), and `busy`, `tx_err`, `rx_err` and `rx_valid` are all 0.
- R2: A transmitted character drives the line low for the start bit from tick 0. Data bit i is driven from tick 2+2i, and the even parity bit (XOR of the data) from tick 18. The line is released at tick 20.
- R3: When no rejection is seen, `busy` falls at tick 23 if `stop_two`=0, or at tick 24 if `stop_two`=1.
- R4: The transmitter samples the line at tick 22. A low level there is a rejection. If a retry is left, the same character is driven again starting at tick 27.
- R5: A rejection with no retry left, or with retry disabled, sets `tx_err` at tick 26 and drops the character, with no further drive.
- R6: A received character with good parity gives a one-cycle `rx_valid` pulse with the byte on `rx_data`, LSB first on the line.
- R7: On bad parity with a receive retry left, the block drives the line low from receive tick 20 to tick 22 (1 ETU, starting half an ETU into the stop period) and delivers no byte.
- R8: On bad parity with no receive retry left, or with receive retry disabled, the block sets `rx_err`, sends no error pulse and delivers no byte.
- R9: The retry count restarts for every new character. Transmit restarts when a byte is accepted. Receive restarts on a good character or a dropped one.
- R10: `tx_valid` is ignored while `busy` is high, and reception is not armed while a transmission is active.
- R11: `tx_err` clears when a new byte is accepted, and `rx_err` clears when the next start bit is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_tick | input | 1 | Strobe, twice per ETU |
| stop_two | input | 1 | 1: two-ETU stop time, 0: one ETU |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_rty_en | input | 1 | Transmit retry enable |
| tx_rty_lim | input | 3 | Transmit retries allowed minus one |
| rx_rty_en | input | 1 | Receive retry enable |
| rx_rty_lim | input | 3 | Receive retries allowed minus one |
| io_in | input | 1 | Level of the shared data line |
| io_drive_low | output | 1 | Pull the shared line low |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | A transmission or reception is in progress |
| tx_err | output | 1 | Transmit retries exhausted |
| rx_err | output | 1 | Receive retries exhausted |

## Verification
A table of characters is run through both directions. The table varies the byte pattern, the number of rejections or corrupted parities, the retry enable, the limit and the stop length. These runs separate a correct retry count from an off-by-one: a rejection count equal to the limit must still succeed, and one more must fail. They also separate a disabled retry from a limit of one, and one stop ETU from two. Byte patterns with odd and even weight, and with asymmetric ends, expose bit-order and parity-sense errors. A byte offered in the middle of a reception confirms that it leaves no trace on the line.

// File: rtl/sc_xcvr_pkg.sv
package sc_xcvr_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_ARM, TX_SEND, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_TAIL, RX_SIGNAL} rx_state_e;
endpackage

// File: rtl/sc_retry_ctr.sv
module sc_retry_ctr #(
    parameter int RTY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fail,
    input  logic             en,
    input  logic [RTY_W-1:0] limit,
    output logic             allow
);
    logic [RTY_W:0] used;

    assign allow = en && (used <= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              used <= '0;
        else if (clr)            used <= '0;
        else if (fail && allow)  used <= used + 1'b1;
    end
endmodule

// File: rtl/sc_tx_fsm.sv
module sc_tx_fsm
    import sc_xcvr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] data_in,
    input  logic              stop_two,
    input  logic              line_in,
    input  logic              allow,
    output logic              active,
    output logic              drive_low,
    output logic              fail,
    output logic              err
);
    localparam int PAR_I   = 2 * (DATA_W + 1);
    localparam int RETRY_I = PAR_I + 8;
    localparam int CW      = $clog2(RETRY_I + 2);
    localparam logic [CW-1:0] STOP_T  = CW'(PAR_I + 2);
    localparam logic [CW-1:0] SAMP_T  = CW'(PAR_I + 4);
    localparam logic [CW-1:0] END1_T  = CW'(PAR_I + 5);
    localparam logic [CW-1:0] END2_T  = CW'(PAR_I + 6);
    localparam logic [CW-1:0] RETRY_T = CW'(RETRY_I);

    tx_state_e         state, nxt;
    logic [CW-1:0]     cnt;
    logic [DATA_W:0]   sh;
    logic [DATA_W-1:0] dat;
    logic              line_hi, rej;

    assign active    = (state != TX_IDLE);
    assign drive_low = !line_hi;
    assign fail      = tick && (state == TX_STOP) && rej && (cnt == RETRY_T);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE: if (start) nxt = TX_ARM;
            TX_ARM:  if (tick) nxt = TX_SEND;
            TX_SEND: if (tick && cnt == STOP_T) nxt = TX_STOP;
            TX_STOP: if (tick) begin
                if (rej) begin
                    if (cnt == RETRY_T) nxt = allow ? TX_ARM : TX_IDLE;
                end else if (cnt == (stop_two ? END2_T : END1_T)) begin
                    nxt = TX_IDLE;
                end
            end
            default: nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            sh      <= '0;
            dat     <= '0;
            line_hi <= 1'b1;
            rej     <= 1'b0;
            err     <= 1'b0;
        end else begin
            if (state == TX_IDLE && start) begin
                dat <= data_in;
                err <= 1'b0;
            end
            if (tick) begin
                unique case (state)
                    TX_ARM: begin
                        line_hi <= 1'b0;
                        sh      <= {^dat, dat};
                        cnt     <= CW'(1);
                        rej     <= 1'b0;
                    end
                    TX_SEND: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == STOP_T) begin
                            line_hi <= 1'b1;
                        end else if (!cnt[0]) begin
                            line_hi <= sh[0];
                            sh      <= sh >> 1;
                        end
                    end
                    TX_STOP: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == SAMP_T) rej <= !line_in;
                        if (rej && cnt == RETRY_T && !allow) err <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_released_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE) |-> !drive_low);
    assert_err_only_exhausted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(!allow));
    assert_resend_on_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && allow) |=> (state == TX_ARM));
endmodule

// File: rtl/sc_rx_fsm.sv
module sc_rx_fsm
    import sc_xcvr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic              line_in,
    input  logic              allow,
    output logic              active,
    output logic              sig_low,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              err,
    output logic              fail,
    output logic              clr
);
    localparam int PAR_I = 2 * (DATA_W + 1);
    localparam int CW    = $clog2(PAR_I + 8);
    localparam logic [CW-1:0] PAR_T   = CW'(PAR_I);
    localparam logic [CW-1:0] TAIL_T  = CW'(PAR_I + 2);
    localparam logic [CW-1:0] SIG_ON  = CW'(PAR_I + 2);
    localparam logic [CW-1:0] SIG_OFF = CW'(PAR_I + 4);
    localparam logic [CW-1:0] SIG_END = CW'(PAR_I + 5);

    rx_state_e         state, nxt;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] sh;
    logic              perr, at_par;

    assign perr   = ^{sh, line_in};
    assign at_par = tick && (state == RX_BITS) && (cnt == PAR_T);
    assign fail   = at_par && perr;
    assign clr    = at_par && (!perr || !allow);
    assign active = (state != RX_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:   if (tick && enable && !line_in) nxt = RX_BITS;
            RX_BITS:   if (at_par) nxt = (perr && allow) ? RX_SIGNAL : RX_TAIL;
            RX_TAIL:   if (tick && cnt == TAIL_T) nxt = RX_IDLE;
            RX_SIGNAL: if (tick && cnt == SIG_END) nxt = RX_IDLE;
            default:   nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            sh       <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            sig_low  <= 1'b0;
            err      <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (tick) begin
                unique case (state)
                    RX_IDLE: if (enable && !line_in) begin
                        cnt <= CW'(1);
                        err <= 1'b0;
                    end
                    RX_BITS: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == PAR_T) begin
                            if (!perr) begin
                                rx_data  <= sh;
                                rx_valid <= 1'b1;
                            end else if (!allow) begin
                                err <= 1'b1;
                            end
                        end else if (!cnt[0]) begin
                            sh <= {line_in, sh[DATA_W-1:1]};
                        end
                    end
                    RX_TAIL: cnt <= cnt + 1'b1;
                    RX_SIGNAL: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == SIG_ON)  sig_low <= 1'b1;
                        if (cnt == SIG_OFF) sig_low <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    assert_signal_scope_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sig_low |-> (state == RX_SIGNAL));
    assert_no_byte_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !rx_valid);
endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr #(
    parameter int DATA_W = 8,
    parameter int RTY_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              stop_two,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_rty_en,
    input  logic [RTY_W-1:0]  tx_rty_lim,
    input  logic              rx_rty_en,
    input  logic [RTY_W-1:0]  rx_rty_lim,
    input  logic              io_in,
    output logic              io_drive_low,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              tx_err,
    output logic              rx_err
);
    localparam int NDIR = 2;

    logic tx_active, rx_active, tx_drive, rx_sig, start;
    logic [NDIR-1:0]  r_en, r_clr, r_fail, r_allow;
    logic [RTY_W-1:0] r_lim [NDIR];

    assign busy         = tx_active || rx_active;
    assign start        = tx_valid && !busy;
    assign io_drive_low = tx_drive || rx_sig;

    assign r_en[0]  = tx_rty_en;
    assign r_lim[0] = tx_rty_lim;
    assign r_clr[0] = start;
    assign r_en[1]  = rx_rty_en;
    assign r_lim[1] = rx_rty_lim;

    for (genvar g = 0; g < NDIR; g++) begin : g_rty
        sc_retry_ctr #(.RTY_W(RTY_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .clr(r_clr[g]), .fail(r_fail[g]),
            .en(r_en[g]), .limit(r_lim[g]), .allow(r_allow[g])
        );
    end

    sc_tx_fsm #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(half_tick), .start(start),
        .data_in(tx_data), .stop_two(stop_two), .line_in(io_in),
        .allow(r_allow[0]), .active(tx_active), .drive_low(tx_drive),
        .fail(r_fail[0]), .err(tx_err)
    );

    sc_rx_fsm #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(half_tick), .enable(!tx_active),
        .line_in(io_in), .allow(r_allow[1]), .active(rx_active),
        .sig_low(rx_sig), .rx_valid(rx_valid), .rx_data(rx_data),
        .err(rx_err), .fail(r_fail[1]), .clr(r_clr[1])
    );

    assert_half_duplex_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_drive && rx_sig));
    assert_no_tx_during_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_active) |-> $past(!rx_active));
endmodule

// File: tb/sc_char_xcvr_test.sv
module sc_char_xcvr_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_tick = 1'b0;
    logic       stop_two = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_rty_en = 1'b0;
    logic [2:0] tx_rty_lim = 3'd0;
    logic       rx_rty_en = 1'b0;
    logic [2:0] rx_rty_lim = 3'd0;
    logic       card_low = 1'b0;
    logic       io_drive_low, rx_valid, busy, tx_err, rx_err;
    logic [7:0] rx_data;
    wire        io_line = !(io_drive_low || card_low);

    int checks = 0, errors = 0;
    int tcount = 0, drive_cnt = 0, rx_cnt = 0, div = 0;
    logic [7:0] rx_last = 8'h00;

    sc_char_xcvr uut (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .stop_two(stop_two),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_rty_en(tx_rty_en),
        .tx_rty_lim(tx_rty_lim), .rx_rty_en(rx_rty_en), .rx_rty_lim(rx_rty_lim),
        .io_in(io_line), .io_drive_low(io_drive_low), .rx_valid(rx_valid),
        .rx_data(rx_data), .busy(busy), .tx_err(tx_err), .rx_err(rx_err)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        div       <= (div == 3) ? 0 : div + 1;
        half_tick <= rst_n && (div == 3);
    end

    always @(posedge clk) begin
        if (rst_n && half_tick) tcount <= tcount + 1;
        if (io_drive_low) drive_cnt <= drive_cnt + 1;
        if (rx_valid) begin
            rx_cnt  <= rx_cnt + 1;
            rx_last <= rx_data;
        end
    end

    // {tx?, byte, bad count, retry en, limit field, two stop}
    localparam int NV = 14;
    localparam logic [17:0] VECS [NV] = '{
        {1'b1, 8'hA5, 4'd0, 1'b0, 3'd0, 1'b0},
        {1'b1, 8'h3C, 4'd0, 1'b0, 3'd0, 1'b1},
        {1'b1, 8'h81, 4'd2, 1'b1, 3'd3, 1'b1},
        {1'b1, 8'h7E, 4'd4, 1'b1, 3'd3, 1'b0},
        {1'b1, 8'h0F, 4'd3, 1'b1, 3'd1, 1'b0},
        {1'b1, 8'hF0, 4'd1, 1'b0, 3'd0, 1'b0},
        {1'b1, 8'h00, 4'd0, 1'b1, 3'd0, 1'b0},
        {1'b1, 8'h99, 4'd8, 1'b1, 3'd7, 1'b1},
        {1'b0, 8'h96, 4'd0, 1'b0, 3'd0, 1'b0},
        {1'b0, 8'hFF, 4'd1, 1'b1, 3'd0, 1'b0},
        {1'b0, 8'h12, 4'd2, 1'b1, 3'd0, 1'b0},
        {1'b0, 8'h34, 4'd1, 1'b0, 3'd0, 1'b0},
        {1'b0, 8'hC3, 4'd0, 1'b0, 3'd0, 1'b0},
        {1'b0, 8'h01, 4'd8, 1'b1, 3'd7, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_tc(input int t);
        while (tcount < t) @(negedge clk);
    endtask

    task automatic tx_vec(input logic [7:0] d, input int bad, input bit en,
                          input logic [2:0] lim, input bit s2);
        int allowed, tries, tk0, dc;
        bit experr;
        logic [9:0] got;
        allowed = en ? int'(lim) + 1 : 0;
        experr  = bad > allowed;
        tries   = experr ? allowed + 1 : bad + 1;
        tx_rty_en = en; tx_rty_lim = lim; stop_two = s2;
        @(negedge clk); tx_valid = 1'b1; tx_data = d;
        @(negedge clk); tx_valid = 1'b0;
        chk(tx_err == 1'b0, "R11 tx_err cleared on accept", tx_err, 0);
        tk0 = tcount;
        for (int k = 0; k < tries; k++) begin
            while (!io_drive_low) @(negedge clk);
            tk0 = tcount;
            for (int j = 0; j < 10; j++) begin
                wait_tc(tk0 + 2 * j + 1);
                got[j] = io_line;
            end
            chk(got == {^d, d, 1'b0}, "R2 tx frame bits", got, {^d, d, 1'b0});
            if (k < bad) begin
                wait_tc(tk0 + 21); card_low = 1'b1;
                wait_tc(tk0 + 23); card_low = 1'b0;
            end else begin
                wait_tc(tk0 + 23);
                chk(busy == s2, "R3 busy at tick 23", busy, s2);
                wait_tc(tk0 + 24);
                chk(busy == 1'b0, "R3 busy at tick 24", busy, 0);
            end
        end
        wait_tc(tk0 + 27);
        dc = drive_cnt;
        wait_tc(tcount + 40);
        chk(drive_cnt == dc, "R4 R5 R9 no launch beyond retry count", drive_cnt - dc, 0);
        chk(tx_err == experr, "R5 tx_err after character", tx_err, experr);
    endtask

    task automatic rx_vec(input logic [7:0] d, input int bad, input bit en,
                          input logic [2:0] lim, input bit poke);
        int allowed, e, rc, dc;
        bit corrupt, expsig, sig, ok_char;
        logic [9:0] fr;
        allowed = en ? int'(lim) + 1 : 0;
        rx_rty_en = en; rx_rty_lim = lim;
        ok_char = 1'b0;
        dc = drive_cnt;
        for (int k = 0; k <= bad; k++) begin
            corrupt = k < bad;
            expsig  = corrupt && (k < allowed);
            wait_tc(tcount + 2);
            e  = tcount;
            rc = rx_cnt;
            dc = drive_cnt;
            fr = {(^d) ^ corrupt, d, 1'b0};
            for (int j = 0; j < 10; j++) begin
                wait_tc(e + 2 * j);
                card_low = !fr[j];
                if (j == 3) begin
                    chk(rx_err == 1'b0, "R11 rx_err cleared at start bit", rx_err, 0);
                    if (poke) begin
                        tx_valid = 1'b1; tx_data = 8'hEE;
                        @(negedge clk); tx_valid = 1'b0;
                    end
                end
            end
            wait_tc(e + 20); card_low = 1'b0;
            wait_tc(e + 22);
            sig = !io_line;
            chk(sig == expsig, "R7 R8 error pulse at stop", sig, expsig);
            wait_tc(e + 26);
            if (!corrupt) begin
                chk(rx_cnt == rc + 1 && rx_last == d, "R6 R9 byte delivered", rx_last, d);
                ok_char = 1'b1;
                break;
            end
            chk(rx_cnt == rc, "R7 R8 bad character withheld", rx_cnt - rc, 0);
            if (!expsig) break;
        end
        chk(rx_err == !ok_char, "R8 rx_err after character", rx_err, !ok_char);
        if (poke) begin
            wait_tc(tcount + 20);
            chk(drive_cnt == dc, "R10 byte offered while busy not sent", drive_cnt - dc, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [17:0] v;
        repeat (5) @(negedge clk);
        chk(io_drive_low == 1'b0 && busy == 1'b0, "R1 line and busy in reset",
            {io_drive_low, busy}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(io_drive_low == 1'b0 && busy == 1'b0 && tx_err == 1'b0 && rx_err == 1'b0
            && rx_cnt == 0, "R1 state after reset",
            {io_drive_low, busy, tx_err, rx_err}, 0);
        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            if (v[17]) tx_vec(v[16:9], int'(v[8:5]), v[4], v[3:1], v[0]);
            else       rx_vec(v[16:9], int'(v[8:5]), v[4], v[3:1], 1'b0);
        end
        rx_vec(8'h5A, 0, 1'b0, 3'd0, 1'b1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule